// File: doc/BRIEF.md
# Quadrature Count Pulse Converter

This block turns the two phase-shifted signals of an incremental encoder into count pulses that a plain up/down counter can consume. Both encoder lines are brought into the system clock domain by a two-flop synchronizer. Each line then passes a stability filter, which accepts a new level only after that level has held for a set number of cycles. A decoder compares the filtered pair with the pair it saw one cycle earlier. A one-shot then emits an active-low pulse whose width comes from an input register.

Two output formats are driven together from the same decoded event:
- Separate up and down strobes.
- A single merged strobe plus a direction level. The direction level is settled before the merged strobe rises, so a counter that counts on that rising edge gets the right direction.

While a pulse is being emitted, line changes are dropped. This rejects the extra counts that a dithering encoder would otherwise produce.

Top module: `qdc_converter`

## Requirements
- R1: With `mode_sel` = 2'b00 (x1), a pulse is produced only when filtered A rises: up if B is low at that moment, down if B is high. Falling A and any B edge produce nothing.
- R2: With `mode_sel` = 2'b01 (x2), both edges of A produce a pulse and B edges produce none.
- R3: With `mode_sel` = 2'b10 or 2'b11 (x4), every single-line change of A or B produces a pulse.
- R4: The line pair {A,B} stepping 00→10→11→01→00 is forward and pulses `up_n`. The reverse order pulses `dn_n`. Both strobes idle high.
- R5: `clk_n` is low exactly when `up_n` or `dn_n` is low, and `up_n` and `dn_n` are never low together.
- R6: `dir` is 1 for a forward pulse and 0 for a reverse pulse. It changes only in the cycle in which `clk_n` falls and holds through the whole pulse.
- R7: After synchronization, a new line level is accepted only once it has held for `VALID_CYC` consecutive cycles. A level that lasts `VALID_CYC`-1 cycles produces no pulse.
- R8: Each pulse stays low for `pulse_width` cycles, and a `pulse_width` of 0 gives a one-cycle pulse.
- R9: Line changes that are accepted while a pulse is low are dropped, not queued. No pulse follows them.
- R10: A change of both filtered lines in the same cycle produces no pulse.
- R11: After reset, `up_n`, `dn_n` and `clk_n` are high and `dir` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 1 | Encoder line A, asynchronous |
| b_in | input | 1 | Encoder line B, asynchronous |
| mode_sel | input | 2 | Resolution: 00 x1, 01 x2, 1x x4 |
| pulse_width | input | WIDTH_W | Pulse length in clock cycles, sampled at pulse start |
| up_n | output | 1 | Active-low forward strobe |
| dn_n | output | 1 | Active-low reverse strobe |
| clk_n | output | 1 | Active-low merged strobe |
| dir | output | 1 | Direction level, 1 forward |

## Verification
The bench keeps the default `VALID_CYC` of 4 and the 8-bit `pulse_width`. A stable level of 3 cycles against one of 4 cycles therefore tests the exact acceptance edge of the filter. The 8-bit width allows pulses of 30 cycles, longer than the filter latency, so a second line change can be placed inside a running pulse to check that it is dropped. Width values of 0 and 1 bring the clamp and back-to-back pulses within reach.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic [1:0] {
    RES_X1 = 2'b00,
    RES_X2 = 2'b01,
    RES_X4 = 2'b10
  } res_e;

  // Two-bit select to resolution; both upper codes mean x4.
  function automatic res_e res_decode(input logic [1:0] sel);
    case (sel)
      2'b00:   return RES_X1;
      2'b01:   return RES_X2;
      default: return RES_X4;
    endcase
  endfunction

  // Forward test for a single-line change, given the new line levels.
  function automatic logic step_is_fwd(input logic on_a, input logic na, input logic nb);
    return on_a ? (na ^ nb) : ~(na ^ nb);
  endfunction

  // Whether the chosen resolution counts this change.
  function automatic logic step_counts(input res_e res, input logic on_a, input logic na);
    case (res)
      RES_X1:  return on_a & na;
      RES_X2:  return on_a;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/qdc_in_filter.sv
module qdc_in_filter #(
  parameter int VALID_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(VALID_CYC + 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [CW-1:0]          hold_q;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_o = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      filt_q <= 1'b0;
    end else if (sync_o == filt_q) begin
      hold_q <= '0;
    end else if (hold_q == CW'(VALID_CYC - 1)) begin
      hold_q <= '0;
      filt_q <= sync_o;
    end else begin
      hold_q <= hold_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/qdc_edge_decoder.sv
module qdc_edge_decoder
  import qdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_f,
  input  logic       b_f,
  input  logic [1:0] mode_sel,
  input  logic       busy,
  output logic       ev_valid,
  output logic       ev_fwd
);
  logic pa_q, pb_q;
  logic a_chg, b_chg, counts;
  res_e res;

  // Previous pair is always refreshed: changes seen while busy are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= a_f;
      pb_q <= b_f;
    end
  end

  always_comb begin
    res    = res_decode(mode_sel);
    a_chg  = a_f ^ pa_q;
    b_chg  = b_f ^ pb_q;
    ev_fwd = step_is_fwd(a_chg, a_f, b_f);
    counts = step_counts(res, a_chg, a_f);
    ev_valid = (a_chg ^ b_chg) & counts & ~busy;
  end
endmodule

// File: rtl/qdc_pulse_gen.sv
module qdc_pulse_gen #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               fwd,
  input  logic [WIDTH_W-1:0] width,
  output logic               active,
  output logic               dir_q
);
  logic [WIDTH_W-1:0] left_q;
  logic [WIDTH_W-1:0] width_eff;

  assign width_eff = (width == '0) ? WIDTH_W'(1) : width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      dir_q  <= 1'b1;
    end else if (start) begin
      left_q <= width_eff;
      dir_q  <= fwd;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/qdc_converter.sv
module qdc_converter #(
  parameter int VALID_CYC = 4,
  parameter int WIDTH_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_in,
  input  logic               b_in,
  input  logic [1:0]         mode_sel,
  input  logic [WIDTH_W-1:0] pulse_width,
  output logic               up_n,
  output logic               dn_n,
  output logic               clk_n,
  output logic               dir
);
  logic [1:0] raw_v, sync_v, filt_v;
  logic a_sync, b_sync, a_filt, b_filt;
  logic ev_valid, ev_fwd, busy, pdir;

  assign raw_v = {b_in, a_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    qdc_in_filter #(.VALID_CYC(VALID_CYC), .SYNC_STAGES(2)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_v[g]),
      .sync_o (sync_v[g]),
      .filt_o (filt_v[g])
    );
  end

  assign a_sync = sync_v[0];
  assign b_sync = sync_v[1];
  assign a_filt = filt_v[0];
  assign b_filt = filt_v[1];

  qdc_edge_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_f      (a_filt),
    .b_f      (b_filt),
    .mode_sel (mode_sel),
    .busy     (busy),
    .ev_valid (ev_valid),
    .ev_fwd   (ev_fwd)
  );

  qdc_pulse_gen #(.WIDTH_W(WIDTH_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ev_valid),
    .fwd    (ev_fwd),
    .width  (pulse_width),
    .active (busy),
    .dir_q  (pdir)
  );

  assign clk_n = ~busy;
  assign up_n  = ~(busy & pdir);
  assign dn_n  = ~(busy & ~pdir);
  assign dir   = pdir;
endmodule

// File: rtl/qdc_converter_chk.sv
module qdc_converter_chk (
  input logic clk,
  input logic rst_n,
  input logic up_n,
  input logic dn_n,
  input logic clk_n,
  input logic dir,
  input logic a_sync,
  input logic b_sync,
  input logic a_filt,
  input logic b_filt,
  input logic ev_valid
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_n && !dn_n));

  p_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_n == (up_n && dn_n));

  p_up_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !up_n |-> dir);

  p_dn_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_n |-> !dir);

  p_dir_only_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir) |-> $fell(clk_n));

  p_start_follows_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_n) |-> $past(ev_valid));

  p_event_starts_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !clk_n);

  p_a_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a_filt) |-> ($past(a_sync) == a_filt));

  p_b_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(b_filt) |-> ($past(b_sync) == b_filt));
endmodule

bind qdc_converter qdc_converter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_n     (up_n),
  .dn_n     (dn_n),
  .clk_n    (clk_n),
  .dir      (dir),
  .a_sync   (a_sync),
  .b_sync   (b_sync),
  .a_filt   (a_filt),
  .b_filt   (b_filt),
  .ev_valid (ev_valid)
);

// File: tb/qdc_converter_tb_top.sv
module qdc_converter_tb_top;
  localparam int VALID = 4;
  localparam int WW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_in = 1'b0, b_in = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic [WW-1:0] pulse_width = 8'd3;
  logic up_n, dn_n, clk_n, dir;

  always #5 clk = ~clk;

  qdc_converter #(.VALID_CYC(VALID), .WIDTH_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .mode_sel(mode_sel), .pulse_width(pulse_width),
    .up_n(up_n), .dn_n(dn_n), .clk_n(clk_n), .dir(dir)
  );

  int total = 0, bad = 0, seen = 0;
  bit done = 0;
  bit exp_q[$];
  int exp_w = 3;
  logic ma = 0, mb = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gpos(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Reference model: update state, push expected direction when counted.
  task automatic model(input logic na, input logic nb, input bit live);
    bit a_moved, b_moved, fwd, take;
    a_moved = (na != ma);
    b_moved = (nb != mb);
    fwd = (gpos(na, nb) == ((gpos(ma, mb) + 1) % 4));
    case (mode_sel)
      2'b00: take = a_moved && na;
      2'b01: take = a_moved;
      default: take = 1'b1;
    endcase
    if (live && (a_moved != b_moved) && take) exp_q.push_back(fwd);
    ma = na;
    mb = nb;
  endtask

  task automatic settle();
    repeat (VALID + 10 + exp_w) @(negedge clk);
  endtask

  task automatic step(input logic na, input logic nb);
    @(negedge clk);
    model(na, nb, 1'b1);
    a_in = na;
    b_in = nb;
    settle();
  endtask

  task automatic set_width(input int w);
    pulse_width = WW'(w);
    exp_w = (w == 0) ? 1 : w;
  endtask

  // Monitor: pops expected pulses and measures their shape.
  bit prev_clk_n = 1;
  int low_len = 0;
  bit cur_fwd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_clk_n && !clk_n) begin
        seen++;
        low_len = 1;
        cur_fwd = dir;
        if (exp_q.size() == 0) begin
          check(0, "R9/R10 unexpected pulse", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(dir == e, "R6 dir level", dir, e);
          check((e ? !up_n && dn_n : up_n && !dn_n), "R4 strobe line", {up_n, dn_n}, e ? 1 : 2);
        end
      end else if (!clk_n) begin
        low_len++;
        if (dir != cur_fwd) check(0, "R6 dir held", dir, cur_fwd);
      end else if (!prev_clk_n && clk_n) begin
        check(low_len == exp_w, "R8 width", low_len, exp_w);
        check(dir == cur_fwd, "R6 dir at rise", dir, cur_fwd);
      end
      if (!up_n && !dn_n) check(0, "R5 both low", 0, 1);
      if (clk_n != (up_n && dn_n)) check(0, "R5 merge", clk_n, up_n && dn_n);
      prev_clk_n = clk_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    check(up_n && dn_n && clk_n && dir, "R11 reset outputs", {up_n, dn_n, clk_n, dir}, 15);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(up_n && dn_n && clk_n && dir, "R11 after release", {up_n, dn_n, clk_n, dir}, 15);

    // R3 / R4: x4 forward then reverse
    mode_sel = 2'b10;
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    check(seen == 8, "R3 x4 count", seen, 8);

    // R2: x2
    mode_sel = 2'b01; s0 = seen;
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    check(seen - s0 == 4, "R2 x2 count", seen - s0, 4);

    // R1: x1
    mode_sel = 2'b00; s0 = seen;
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    check(seen - s0 == 2, "R1 x1 count", seen - s0, 2);

    // R3: code 11 is also x4
    mode_sel = 2'b11; s0 = seen;
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    check(seen - s0 == 4, "R3 code 11 count", seen - s0, 4);

    // R8: width clamp and longer width
    set_width(0); step(1, 0);
    set_width(7); step(1, 1);

    // R7: a 3-cycle level is rejected
    set_width(1); s0 = seen;
    @(negedge clk); b_in = ~mb;
    repeat (VALID - 1) @(negedge clk);
    b_in = mb;
    settle();
    check(seen == s0, "R7 short level rejected", seen - s0, 0);

    // R7: a 4-cycle level is accepted (two pulses: there and back)
    @(negedge clk);
    model(~ma, mb, 1'b1); a_in = ma;
    repeat (VALID) @(negedge clk);
    model(~ma, mb, 1'b1); a_in = ma;
    settle();
    check(seen - s0 == 2, "R7 held level accepted", seen - s0, 2);

    // R10: both lines change together
    s0 = seen;
    @(negedge clk);
    model(~ma, ~mb, 1'b1); a_in = ma; b_in = mb;
    settle();
    check(seen == s0, "R10 double change", seen - s0, 0);

    // R9: change inside a long pulse is dropped
    set_width(30); s0 = seen;
    @(negedge clk);
    model(~ma, mb, 1'b1); a_in = ma;
    repeat (12) @(negedge clk);
    model(ma, ~mb, 1'b0); b_in = mb;
    settle();
    check(seen - s0 == 1, "R9 inhibited change", seen - s0, 1);
    set_width(2); step(~ma, mb);
    check(seen - s0 == 2, "R9 resumes after pulse", seen - s0, 2);

    check(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule